// File: doc/BRIEF.md
# DMA Status and Interrupt Counter

This block records what a chained-command DMA engine has reported since it was last started. The engine sends one-cycle event pulses: it finished its command list, a remote-bus error hit a data transfer, a local-bus error hit a command fetch, a local timeout hit a data transfer, or an interrupt was sent to the local interrupter. Each event sets a sticky bit in an 8-bit status byte. Each interrupt pulse advances a 4-bit counter. In chained mode, that counter equals the number of commands processed.

A fetch error carries a 4-bit cause qualifier decoded from the bus termination status. The qualifier is copied into the status byte together with the fetch-error flag. A one-cycle start pulse from the engine's enable path clears the byte and the counter. Software reads both values through a small register read port. Each read answers one cycle after the request. A read changes nothing.

The read port is driven by a two-state machine. In `RD_IDLE`, the port output is zero. When `rd_en` is seen, the machine takes the `take_request` transition into `RD_DRIVE` and captures the selected register. In `RD_DRIVE`, the captured byte is presented with `rd_valid` high. The machine takes the `finish` transition back to `RD_IDLE`, or stays in `RD_DRIVE` through `chain_request` when another request is present.

Top module: `dma_stat_top`

## Requirements
- R1: Every cycle with `ev_irq` high advances the interrupt count by one. No input gates this counting.
- R2: An interrupt pulse with the count at 15 makes the count 0.
- R3: A cycle with `dma_start` high clears the count and all eight status bits. If a set event or an interrupt pulse arrives in the same cycle, `dma_start` wins and everything reads 0 afterwards.
- R4: Status bit 0 (done) sets on `ev_finish`.
- R5: Status bit 1 (remote error) sets on `ev_remote_err`.
- R6: Status bit 2 (fetch error) sets on `ev_fetch_err`. In that same cycle, `fetch_cause[0..3]` is recorded into status bits 3..6, in the order local timeout, off-board, local parity, local bus error. Without `ev_fetch_err`, `fetch_cause` has no effect.
- R7: Status bit 7 (transfer timeout) sets on `ev_xfer_tmo`.
- R8: Status bits are sticky. Once a bit is set, it stays set through later events until the next `dma_start`.
- R9: A read with `rd_en` high returns its data on the next cycle with `rd_valid` high. Address 0 returns the status byte. Address 1 returns {4'b0, count}. Addresses 2 and 3 return 0. The value returned is the state before that cycle's events. When `rd_valid` is low, `rd_data` is 0. Reads do not change the status byte or the count.
- R10: After reset, the status byte and the count are 0 and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_start | input | 1 | Engine-enable pulse; clears all state |
| ev_finish | input | 1 | Command list finished or halted |
| ev_remote_err | input | 1 | Remote-bus error during a data transfer |
| ev_fetch_err | input | 1 | Local-bus error during a command fetch |
| fetch_cause | input | 4 | Fetch error cause: [0] timeout, [1] off-board, [2] parity, [3] bus error |
| ev_xfer_tmo | input | 1 | Local timeout during a data transfer |
| ev_irq | input | 1 | Interrupt sent to the local interrupter |
| rd_en | input | 1 | Read request |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
The hardest situation to reach is the collision between a clear and a set: a start pulse in the same cycle as a fetch error with all cause bits, an interrupt pulse and every other event. The stimulus first fills the status byte and advances the count, then drives all those inputs together in one cycle. The following read must return zero. The counter wrap also needs a long run: sixteen interrupt pulses take the count past 15, and the reads on either side of the last pulse show the step from 15 to 0.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
    localparam int STAT_W  = 8;
    localparam int CAUSE_W = 4;
    localparam int RADDR_W = 2;

    localparam int B_DONE   = 0;
    localparam int B_REMOTE = 1;
    localparam int B_FETCH  = 2;
    localparam int B_CAUSE0 = 3;
    localparam int B_XTMO   = 7;

    localparam logic [RADDR_W-1:0] A_STATUS = 2'd0;
    localparam logic [RADDR_W-1:0] A_COUNT  = 2'd1;

    typedef enum logic [0:0] {
        RD_IDLE  = 1'b0,
        RD_DRIVE = 1'b1
    } rd_state_t;
endpackage

// File: rtl/dma_stat_flags.sv
module dma_stat_flags
    import dma_stat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               ev_finish,
    input  logic               ev_remote_err,
    input  logic               ev_fetch_err,
    input  logic [CAUSE_W-1:0] fetch_cause,
    input  logic               ev_xfer_tmo,
    output logic [STAT_W-1:0]  status
);
    logic [STAT_W-1:0] set_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[B_DONE]   = ev_finish;
        set_vec[B_REMOTE] = ev_remote_err;
        set_vec[B_FETCH]  = ev_fetch_err;
        set_vec[B_XTMO]   = ev_xfer_tmo;
        for (int i = 0; i < CAUSE_W; i++) begin
            set_vec[B_CAUSE0+i] = ev_fetch_err & fetch_cause[i];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAT_W; g++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          status[g] <= 1'b0;
                else if (clr)        status[g] <= 1'b0;
                else if (set_vec[g]) status[g] <= 1'b1;
            end
        end
    endgenerate

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status & $past(status)) == $past(status)));
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status == '0));
    a_r6_cause_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ev_fetch_err && !status[B_FETCH]) |=> !status[B_FETCH]);
endmodule

// File: rtl/dma_stat_irqcnt.sv
module dma_stat_irqcnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + CNT_ONE;
    end

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc) |=> (count == $past(count) + CNT_ONE));
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(count));
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && count == CNT_MAX) |=> (count == '0));
    a_r3_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/dma_stat_rdport.sv
module dma_stat_rdport
    import dma_stat_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [RADDR_W-1:0] rd_addr,
    input  logic [STAT_W-1:0]  status,
    input  logic [CNT_W-1:0]   count,
    output logic [STAT_W-1:0]  rd_data,
    output logic               rd_valid
);
    rd_state_t         state_q, state_d;
    logic [STAT_W-1:0] sel, cap_q;

    always_comb begin
        unique case (rd_addr)
            A_STATUS: sel = status;
            A_COUNT:  sel = {{(STAT_W-CNT_W){1'b0}}, count};
            default:  sel = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RD_IDLE:  state_d = rd_en ? RD_DRIVE : RD_IDLE;
            RD_DRIVE: state_d = rd_en ? RD_DRIVE : RD_IDLE;
            default:  state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) cap_q <= sel;
        end
    end

    always_comb begin
        unique case (state_q)
            RD_DRIVE: begin rd_valid = 1'b1; rd_data = cap_q; end
            default:  begin rd_valid = 1'b0; rd_data = '0;    end
        endcase
    end

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r9_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));
endmodule

// File: rtl/dma_stat_top.sv
module dma_stat_top
    import dma_stat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dma_start,
    input  logic               ev_finish,
    input  logic               ev_remote_err,
    input  logic               ev_fetch_err,
    input  logic [CAUSE_W-1:0] fetch_cause,
    input  logic               ev_xfer_tmo,
    input  logic               ev_irq,
    input  logic               rd_en,
    input  logic [RADDR_W-1:0] rd_addr,
    output logic [STAT_W-1:0]  rd_data,
    output logic               rd_valid
);
    localparam int CNT_W = 4;

    logic [STAT_W-1:0] status;
    logic [CNT_W-1:0]  count;

    dma_stat_flags u_flags (
        .clk(clk), .rst_n(rst_n), .clr(dma_start),
        .ev_finish(ev_finish), .ev_remote_err(ev_remote_err),
        .ev_fetch_err(ev_fetch_err), .fetch_cause(fetch_cause),
        .ev_xfer_tmo(ev_xfer_tmo), .status(status)
    );

    dma_stat_irqcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(dma_start), .inc(ev_irq), .count(count)
    );

    dma_stat_rdport #(.CNT_W(CNT_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .status(status), .count(count), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: tb/dma_stat_top_test.sv
module dma_stat_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_start = 0, ev_finish = 0, ev_remote_err = 0, ev_fetch_err = 0;
    logic [3:0] fetch_cause = '0;
    logic       ev_xfer_tmo = 0, ev_irq = 0, rd_en = 0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int   n_tests = 0, n_fail = 0;
    bit   finished = 0;
    logic [7:0] m_stat = '0;
    logic [3:0] m_cnt  = '0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    dma_stat_top uut (
        .clk(clk), .rst_n(rst_n), .dma_start(dma_start), .ev_finish(ev_finish),
        .ev_remote_err(ev_remote_err), .ev_fetch_err(ev_fetch_err),
        .fetch_cause(fetch_cause), .ev_xfer_tmo(ev_xfer_tmo), .ev_irq(ev_irq),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // driver: one cycle of stimulus; a read pushes the value before this cycle's events
    task automatic step(input bit st, input bit fin, input bit rem, input bit fe,
                        input logic [3:0] cause, input bit tmo, input bit irq,
                        input bit rd, input logic [1:0] addr, input string tag);
        @(negedge clk);
        dma_start = st; ev_finish = fin; ev_remote_err = rem; ev_fetch_err = fe;
        fetch_cause = cause; ev_xfer_tmo = tmo; ev_irq = irq;
        rd_en = rd; rd_addr = addr;
        if (rd) begin
            case (addr)
                2'd0: exp_q.push_back(m_stat);
                2'd1: exp_q.push_back({4'b0, m_cnt});
                default: exp_q.push_back(8'h00);
            endcase
            tag_q.push_back(tag);
        end
        if (st) begin
            m_stat = '0; m_cnt = '0;
        end else begin
            if (fin) m_stat[0] = 1'b1;
            if (rem) m_stat[1] = 1'b1;
            if (fe)  m_stat[6:2] = m_stat[6:2] | {cause, 1'b1};
            if (tmo) m_stat[7] = 1'b1;
            if (irq) m_cnt = m_cnt + 4'd1;
        end
    endtask

    task automatic idle();
        step(0,0,0,0,4'h0,0,0,0,2'd0,"");
    endtask
    task automatic rd(input logic [1:0] a, input string tag);
        step(0,0,0,0,4'h0,0,0,1,a,tag);
    endtask

    // monitor: compares each returned read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected rd_valid: actual %02h expected none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_tests++;
        if (rd_valid !== 1'b0 || rd_data !== 8'h00) begin
            n_fail++;
            $display("FAIL R10 reset outputs: actual %b/%02h expected 0/00", rd_valid, rd_data);
        end
        rst_n = 1'b1;
        rd(2'd0, "R10 status after reset");
        rd(2'd1, "R10 count after reset");
        // R4 done, R5 remote, R7 xfer timeout
        step(0,1,0,0,4'h0,0,0,0,2'd0,"");
        rd(2'd0, "R4 done bit");
        step(0,0,1,0,4'h0,0,0,0,2'd0,"");
        rd(2'd0, "R5 remote error bit");
        step(0,0,0,0,4'h0,1,0,0,2'd0,"");
        rd(2'd0, "R7 transfer timeout bit");
        // R6 cause without fetch error is ignored
        step(1,0,0,0,4'h0,0,0,0,2'd0,"");
        step(0,0,0,0,4'hF,0,0,0,2'd0,"");
        rd(2'd0, "R6 cause alone ignored");
        step(0,0,0,1,4'b0101,0,0,0,2'd0,"");
        rd(2'd0, "R6 fetch error timeout+parity");
        step(0,0,0,1,4'b1010,0,0,0,2'd0,"");
        rd(2'd0, "R8 sticky cause bits accumulate");
        step(0,1,1,0,4'h0,1,0,1,2'd0,"R9 read sees pre-event value");
        rd(2'd0, "R8 all bits set");
        rd(2'd0, "R9 read has no side effect");
        rd(2'd2, "R9 address 2 reads zero");
        rd(2'd3, "R9 address 3 reads zero");
        // R1 counting, R2 wrap
        for (int i = 0; i < 15; i++) step(0,0,0,0,4'h0,0,1,0,2'd0,"");
        rd(2'd1, "R1 count fifteen");
        step(0,0,0,0,4'h0,0,1,1,2'd1,"R1 back-to-back read");
        rd(2'd1, "R2 wrap to zero");
        step(0,0,0,0,4'h0,0,1,0,2'd0,"");
        step(0,0,0,0,4'h0,0,1,0,2'd0,"");
        rd(2'd1, "R1 count two after wrap");
        rd(2'd0, "R8 status kept through interrupts");
        // R3 start collides with every event
        step(1,1,1,1,4'hF,1,1,0,2'd0,"");
        rd(2'd0, "R3 status cleared despite events");
        rd(2'd1, "R3 count cleared despite irq");
        step(0,0,0,0,4'h0,0,1,0,2'd0,"");
        rd(2'd1, "R1 count resumes after start");
        idle(); idle(); idle();
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        finished = 1;
        summary();
    end
endmodule